// File: doc/BRIEF.md
# Diagnostic Record/Playback Buffer

This block is a debug memory placed on a wide datapath. While it records, it takes one word each time the event-interval strobe fires and writes it into a circular buffer. The word is the live segment data together with the decision bits. A freeze request arms a countdown. After a programmable number of further strobes, the block stops writing and keeps the history that led up to the trigger and followed it.

Once frozen, software can inspect any stored entry through a simple indexed read port, one 32-bit slice at a time. Entry index 0 is always the oldest word. The stored history can also be replayed into the datapath. In playback mode the block's data outputs carry the recorded words in recorded order instead of the live inputs, and it moves to the next word on every strobe. Playback either wraps around without end or stops after one pass. The current mode, the latched pointer and a buffer-full flag are visible at all times.

Top module: `dbg_replay_buf`

## Requirements
- R1: After reset the block is in mode IDLE, the latched pointer is 0, the full flag is 0 and rd_valid is 0.
- R2: Mode codes are IDLE=0, RECORD=1, FROZEN=2, PLAYBACK=3. Command priority is stop > record > play. cmd_stop sends any mode to IDLE on the next cycle. cmd_rec moves IDLE or FROZEN to RECORD. cmd_play moves IDLE or FROZEN to PLAYBACK. Commands not listed for a mode are ignored.
- R3: In RECORD, each strobe writes the word {dec_in, seg_in} (seg_in in the low bits) to the next slot of a DEPTH-entry ring. No slot is written in any other mode.
- R4: A trig seen in RECORD with no countdown running arms a countdown of post_cnt. After exactly post_cnt further strobes have been recorded, the block enters FROZEN on the following cycle. If post_cnt is 0, it enters FROZEN on the cycle after the trig. A trig while a countdown runs is ignored.
- R5: Each exit from RECORD latches the write pointer (the slot of the oldest entry) into frz_ptr. frz_ptr changes at no other time.
- R6: full becomes 1 on the DEPTH-th write after reset and stays 1 until reset.
- R7: A read with rd_en in IDLE or FROZEN returns rd_valid=1 one cycle later. rd_data then holds bits [32*rd_sel+31 : 32*rd_sel] of the entry at slot (frz_ptr + rd_idx) mod DEPTH, zero-padded above the word. A rd_sel past the last 32-bit slice returns 0.
- R8: A read in RECORD or PLAYBACK gives rd_valid=0. Whenever rd_valid is 0, rd_data is 0.
- R9: In PLAYBACK the data outputs show the playback register. This register is 0 on entry. On each strobe it loads the next entry, starting at slot frz_ptr, and the new value is visible from the cycle after the strobe.
- R10: With single_shot=0, playback wraps: the entry shown after the (DEPTH+1)-th strobe is the oldest entry again.
- R11: With single_shot=1, the block returns to FROZEN on the first strobe after DEPTH entries have been shown.
- R12: Outside PLAYBACK, seg_out and dec_out equal seg_in and dec_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_stb | input | 1 | Event-interval strobe, one cycle wide |
| cmd_rec | input | 1 | Start or resume recording |
| cmd_stop | input | 1 | Return to IDLE |
| cmd_play | input | 1 | Start playback |
| trig | input | 1 | Freeze request |
| post_cnt | input | CNT_W | Number of strobes recorded after a trigger |
| single_shot | input | 1 | Playback stops after one pass |
| seg_in | input | NSEG*SEG_W | Live segment data |
| dec_in | input | DEC_W | Live decision bits |
| seg_out | output | NSEG*SEG_W | Segment data toward the datapath |
| dec_out | output | DEC_W | Decision bits toward the datapath |
| rd_en | input | 1 | Readback request |
| rd_idx | input | PTR_W | Entry index, 0 = oldest |
| rd_sel | input | SEL_W | 32-bit slice select |
| rd_data | output | 32 | Readback data |
| rd_valid | output | 1 | Readback data valid |
| mode | output | 2 | Current mode code |
| frz_ptr | output | PTR_W | Latched write pointer |
| full | output | 1 | DEPTH writes seen since reset |

## Verification
The hardest state to reach is a freeze whose countdown crosses the ring wrap while a second trigger arrives during the countdown. Only after that can readback and playback show whether the oldest-entry offset is right. The stimulus records more than DEPTH strobes so that the ring has wrapped and full is set. It then pulses trig, pulses it again before the post-trigger strobes end, and reads every index. After that it runs playback past one full pass in both continuous and single-shot modes.

// File: rtl/dbg_replay_pkg.sv
package dbg_replay_pkg;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_REC    = 2'd1,
    M_FROZEN = 2'd2,
    M_PLAY   = 2'd3
  } rb_mode_e;

  // number of 32-bit readback slices needed for a word of the given width
  function automatic int words_for(input int bits);
    return (bits + 31) / 32;
  endfunction

endpackage

// File: rtl/rb_mode_ctrl.sv
module rb_mode_ctrl
  import dbg_replay_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_stb,
  input  logic             cmd_rec,
  input  logic             cmd_stop,
  input  logic             cmd_play,
  input  logic             trig,
  input  logic [CNT_W-1:0] post_cnt,
  input  logic             single_shot,
  output logic [1:0]       mode,
  output logic             wr_en,
  output logic             latch_ptr,
  output logic             pb_start,
  output logic             pb_load,
  output logic [PTR_W-1:0] pb_ofs
);

  rb_mode_e         mode_q, mode_d;
  logic             armed_q;
  logic [CNT_W-1:0] remain_q;
  logic [PTR_W-1:0] ofs_q;
  logic             pass_q;

  // named internal events
  logic in_rest, rec_start, freeze_due, pb_end, arm_now;

  always_comb begin
    in_rest    = (mode_q == M_IDLE) || (mode_q == M_FROZEN);
    rec_start  = in_rest && !cmd_stop && cmd_rec;
    pb_start   = in_rest && !cmd_stop && !cmd_rec && cmd_play;
    freeze_due = (mode_q == M_REC) && armed_q && (remain_q == '0);
    wr_en      = (mode_q == M_REC) && evt_stb && !cmd_stop && !freeze_due;
    latch_ptr  = (mode_q == M_REC) && (cmd_stop || freeze_due);
    arm_now    = (mode_q == M_REC) && trig && !armed_q && !cmd_stop;
    pb_end     = (mode_q == M_PLAY) && evt_stb && !cmd_stop && single_shot && pass_q;
    pb_load    = (mode_q == M_PLAY) && evt_stb && !cmd_stop && !(single_shot && pass_q);
  end

  always_comb begin
    mode_d = mode_q;
    if (cmd_stop)                    mode_d = M_IDLE;
    else if (rec_start)              mode_d = M_REC;
    else if (pb_start)               mode_d = M_PLAY;
    else if (freeze_due || pb_end)   mode_d = M_FROZEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      armed_q  <= 1'b0;
      remain_q <= '0;
      ofs_q    <= '0;
      pass_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (rec_start || latch_ptr) begin
        armed_q <= 1'b0;
      end else if (arm_now) begin
        armed_q  <= 1'b1;
        remain_q <= post_cnt;
      end else if (wr_en && armed_q) begin
        remain_q <= remain_q - CNT_W'(1);
      end
      if (pb_start) begin
        ofs_q  <= '0;
        pass_q <= 1'b0;
      end else if (pb_load) begin
        if (ofs_q == PTR_W'(DEPTH - 1)) begin
          ofs_q  <= '0;
          pass_q <= 1'b1;
        end else begin
          ofs_q <= ofs_q + PTR_W'(1);
        end
      end
    end
  end

  assign mode   = mode_q;
  assign pb_ofs = ofs_q;

endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 2310,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    din,
  input  logic             latch_ptr,
  input  logic             pb_start,
  input  logic             pb_load,
  input  logic [PTR_W-1:0] pb_ofs,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [DW-1:0]    pb_word,
  output logic [DW-1:0]    rd_row,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] frz_ptr,
  output logic             full
);

  // modular add on the ring of DEPTH slots
  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] a,
                                                input logic [PTR_W-1:0] b);
    logic [PTR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    pb_q;
  logic [PTR_W-1:0] wptr_q, frz_q;
  logic             full_q;
  logic             wrap_now;

  assign wrap_now = wr_en && (wptr_q == PTR_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      frz_q  <= '0;
      full_q <= 1'b0;
      pb_q   <= '0;
    end else begin
      if (wr_en)     wptr_q <= ring_add(wptr_q, PTR_W'(1));
      if (wrap_now)  full_q <= 1'b1;
      if (latch_ptr) frz_q  <= wptr_q;
      if (pb_start)     pb_q <= '0;
      else if (pb_load) pb_q <= mem[ring_add(frz_q, pb_ofs)];
    end
  end

  assign rd_row  = mem[ring_add(frz_q, rd_idx)];
  assign pb_word = pb_q;
  assign wptr    = wptr_q;
  assign frz_ptr = frz_q;
  assign full    = full_q;

endmodule

// File: rtl/rb_readout.sv
module rb_readout #(
  parameter int DW    = 2310,
  parameter int NWORD = 73,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_ok,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [DW-1:0]    row,
  output logic [31:0]      rd_data,
  output logic             rd_valid
);

  logic [NWORD*32-1:0] padded;
  logic [31:0]         slice;
  logic                grant;

  always_comb begin
    padded         = '0;
    padded[DW-1:0] = row;
    slice          = '0;
    if (int'(rd_sel) < NWORD) slice = padded[int'(rd_sel)*32 +: 32];
  end

  assign grant = rd_en && rd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= grant;
      rd_data  <= grant ? slice : 32'd0;
    end
  end

endmodule

// File: rtl/dbg_replay_buf.sv
module dbg_replay_buf
  import dbg_replay_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int NSEG   = 144,
  parameter int SEG_W  = 16,
  parameter int DEC_W  = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SW    = NSEG * SEG_W,
  localparam int DW    = SW + DEC_W,
  localparam int NWORD = words_for(DW),
  localparam int SEL_W = $clog2(NWORD) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_stb,
  input  logic             cmd_rec,
  input  logic             cmd_stop,
  input  logic             cmd_play,
  input  logic             trig,
  input  logic [CNT_W-1:0] post_cnt,
  input  logic             single_shot,
  input  logic [SW-1:0]    seg_in,
  input  logic [DEC_W-1:0] dec_in,
  output logic [SW-1:0]    seg_out,
  output logic [DEC_W-1:0] dec_out,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_idx,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic [1:0]       mode,
  output logic [PTR_W-1:0] frz_ptr,
  output logic             full
);

  logic             wr_en, latch_ptr, pb_start, pb_load, rd_ok, in_play;
  logic [PTR_W-1:0] pb_ofs, wptr;
  logic [DW-1:0]    pb_word, rd_row;

  rb_mode_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .cmd_rec(cmd_rec),
    .cmd_stop(cmd_stop), .cmd_play(cmd_play), .trig(trig), .post_cnt(post_cnt),
    .single_shot(single_shot), .mode(mode), .wr_en(wr_en), .latch_ptr(latch_ptr),
    .pb_start(pb_start), .pb_load(pb_load), .pb_ofs(pb_ofs)
  );

  rb_store #(.DEPTH(DEPTH), .DW(DW), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din({dec_in, seg_in}),
    .latch_ptr(latch_ptr), .pb_start(pb_start), .pb_load(pb_load),
    .pb_ofs(pb_ofs), .rd_idx(rd_idx), .pb_word(pb_word), .rd_row(rd_row),
    .wptr(wptr), .frz_ptr(frz_ptr), .full(full)
  );

  assign rd_ok = (mode == M_IDLE) || (mode == M_FROZEN);

  rb_readout #(.DW(DW), .NWORD(NWORD), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ok(rd_ok), .rd_sel(rd_sel),
    .row(rd_row), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign in_play = (mode == M_PLAY);
  assign seg_out = in_play ? pb_word[SW-1:0] : seg_in;
  assign dec_out = in_play ? pb_word[DW-1 -: DEC_W] : dec_in;

endmodule

// File: rtl/rb_checker.sv
module rb_checker
  import dbg_replay_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             wr_en,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] frz_ptr,
  input logic             full,
  input logic             rd_valid,
  input logic [31:0]      rd_data
);

  // R3
  wr_only_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mode == M_REC));

  // R3
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_REC) |=> $stable(wptr));

  // R6
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  // R5
  frz_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frz_ptr) |-> ($past(mode) == M_REC));

  // R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (($past(mode) == M_IDLE) || ($past(mode) == M_FROZEN)));

  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 32'd0));

  // R4
  frz_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_FROZEN) && ($past(mode) != M_FROZEN)) |->
      (($past(mode) == M_REC) || ($past(mode) == M_PLAY)));

endmodule

bind dbg_replay_buf rb_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wptr(wptr),
  .frz_ptr(frz_ptr), .full(full), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/dbg_replay_buf_bench.sv
module dbg_replay_buf_bench;

  localparam int DEPTH = 8;
  localparam int NSEG  = 3;
  localparam int SEG_W = 16;
  localparam int DEC_W = 6;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SW    = NSEG * SEG_W;
  localparam int DW    = SW + DEC_W;
  localparam int NWORD = (DW + 31) / 32;
  localparam int SEL_W = $clog2(NWORD) + 1;

  logic clk = 0, rst_n = 0;
  logic evt_stb = 0, cmd_rec = 0, cmd_stop = 0, cmd_play = 0, trig = 0, single_shot = 0;
  logic [CNT_W-1:0] post_cnt = '0;
  logic [SW-1:0]    seg_in = '0;
  logic [DEC_W-1:0] dec_in = '0;
  logic [SW-1:0]    seg_out;
  logic [DEC_W-1:0] dec_out;
  logic             rd_en = 0;
  logic [PTR_W-1:0] rd_idx = '0;
  logic [SEL_W-1:0] rd_sel = '0;
  logic [31:0]      rd_data;
  logic             rd_valid;
  logic [1:0]       mode;
  logic [PTR_W-1:0] frz_ptr;
  logic             full;

  int checks = 0, errors = 0;
  bit done = 0;
  int stim_k = 0;

  always #5 clk = ~clk;

  dbg_replay_buf #(.DEPTH(DEPTH), .NSEG(NSEG), .SEG_W(SEG_W), .DEC_W(DEC_W)) u_dbg_replay_buf (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .cmd_rec(cmd_rec), .cmd_stop(cmd_stop),
    .cmd_play(cmd_play), .trig(trig), .post_cnt(post_cnt), .single_shot(single_shot),
    .seg_in(seg_in), .dec_in(dec_in), .seg_out(seg_out), .dec_out(dec_out),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .mode(mode), .frz_ptr(frz_ptr), .full(full)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int             m_mode, m_wp, m_fp, m_rem, m_ofs;
  bit             m_full, m_armed, m_pass, m_rv;
  logic [DW-1:0]  m_mem [DEPTH];
  logic [DW-1:0]  m_pb;
  logic [31:0]    m_rd;

  function automatic logic [31:0] slice_of(input logic [DW-1:0] w, input int sel);
    logic [NWORD*32-1:0] p;
    p = '0;
    p[DW-1:0] = w;
    if (sel >= NWORD) return 32'd0;
    return 32'(p >> (32 * sel));
  endfunction

  task automatic m_play_start();
    m_mode = 3; m_ofs = 0; m_pass = 0; m_pb = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_wp = 0; m_fp = 0; m_rem = 0; m_ofs = 0;
      m_full = 0; m_armed = 0; m_pass = 0; m_rv = 0; m_rd = '0; m_pb = '0;
    end else begin
      bit was_armed;
      m_rv = rd_en && (m_mode == 0 || m_mode == 2);
      m_rd = m_rv ? slice_of(m_mem[(m_fp + int'(rd_idx)) % DEPTH], int'(rd_sel)) : 32'd0;
      was_armed = m_armed;
      case (m_mode)
        0, 2: begin
          if (cmd_stop) m_mode = 0;
          else if (cmd_rec) begin m_mode = 1; m_armed = 0; end
          else if (cmd_play) m_play_start();
        end
        1: begin
          if (cmd_stop) begin m_fp = m_wp; m_mode = 0; m_armed = 0; end
          else if (m_armed && m_rem == 0) begin m_fp = m_wp; m_mode = 2; m_armed = 0; end
          else begin
            if (evt_stb) begin
              m_mem[m_wp] = {dec_in, seg_in};
              if (m_wp == DEPTH - 1) m_full = 1;
              m_wp = (m_wp + 1) % DEPTH;
              if (was_armed) m_rem--;
            end
            if (trig && !was_armed) begin m_armed = 1; m_rem = int'(post_cnt); end
          end
        end
        default: begin
          if (cmd_stop) m_mode = 0;
          else if (evt_stb) begin
            if (single_shot && m_pass) m_mode = 2;
            else begin
              m_pb = m_mem[(m_fp + m_ofs) % DEPTH];
              m_ofs++;
              if (m_ofs == DEPTH) begin m_ofs = 0; m_pass = 1; end
            end
          end
        end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R4 R11 mode", 64'(mode), 64'(m_mode));
      chk("R5 frz_ptr", 64'(frz_ptr), 64'(m_fp));
      chk("R6 full", 64'(full), 64'(m_full));
      chk("R7 R8 rd_valid", 64'(rd_valid), 64'(m_rv));
      chk("R3 R7 R8 rd_data", 64'(rd_data), 64'(m_rd));
      if (m_mode == 3) begin
        chk(m_pass ? "R10 seg_out" : "R9 seg_out", 64'(seg_out), 64'(m_pb[SW-1:0]));
        chk(m_pass ? "R10 dec_out" : "R9 dec_out", 64'(dec_out), 64'(m_pb[DW-1 -: DEC_W]));
      end else begin
        chk("R12 seg_out", 64'(seg_out), 64'(seg_in));
        chk("R12 dec_out", 64'(dec_out), 64'(dec_in));
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic strobe();
    seg_in  = {16'(stim_k * 3 + 1), 16'(stim_k ^ 16'h5a5a), 16'(stim_k + 100)};
    dec_in  = 6'(stim_k * 7);
    stim_k++;
    evt_stb = 1; cyc(); evt_stb = 0;
    cyc(); cyc(); cyc();
  endtask

  task automatic pulse_rec();  cmd_rec = 1;  cyc(); cmd_rec = 0;  cyc(); endtask
  task automatic pulse_stop(); cmd_stop = 1; cyc(); cmd_stop = 0; cyc(); endtask
  task automatic pulse_play(); cmd_play = 1; cyc(); cmd_play = 0; cyc(); endtask

  task automatic rd(input int idx, input int sel);
    rd_en = 1; rd_idx = PTR_W'(idx); rd_sel = SEL_W'(sel);
    cyc(); rd_en = 0; cyc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 mode", 64'(mode), 0);
    chk("R1 frz_ptr", 64'(frz_ptr), 0);
    chk("R1 full", 64'(full), 0);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    rst_n = 1; cyc();

    // short session: 5 writes, then stop
    pulse_rec();
    repeat (5) strobe();
    pulse_stop();
    chk("R5 frz_ptr after stop", 64'(frz_ptr), 5);
    chk("R6 not full yet", 64'(full), 0);
    for (int i = 3; i < DEPTH; i++) for (int s = 0; s < 3; s++) rd(i, s);

    // wrap the ring, read while recording, trigger twice
    pulse_rec();
    repeat (6) strobe();
    chk("R6 full after wrap", 64'(full), 1);
    rd(0, 0);
    post_cnt = CNT_W'(2);
    trig = 1; cyc(); trig = 0;
    strobe();
    trig = 1; cyc(); trig = 0;
    strobe();
    cyc();
    chk("R4 frozen after post count", 64'(mode), 2);
    chk("R5 latched pointer", 64'(frz_ptr), 5);
    for (int i = 0; i < DEPTH; i++) for (int s = 0; s < 3; s++) rd(i, s);

    // resume, trigger with zero post count
    pulse_rec();
    strobe();
    post_cnt = '0;
    trig = 1; cyc(); trig = 0;
    cyc();
    chk("R4 zero post count freezes", 64'(mode), 2);

    // continuous playback across the wrap
    single_shot = 0;
    pulse_play();
    rd(1, 0);
    repeat (DEPTH + 3) strobe();
    chk("R10 still in playback", 64'(mode), 3);
    pulse_stop();

    // single-shot playback from IDLE
    single_shot = 1;
    pulse_play();
    repeat (DEPTH + 2) strobe();
    chk("R11 back to frozen", 64'(mode), 2);
    single_shot = 0;

    // priority: record beats play
    pulse_stop();
    cmd_rec = 1; cmd_play = 1; cyc(); cmd_rec = 0; cmd_play = 0; cyc();
    chk("R2 record wins over play", 64'(mode), 1);
    strobe();
    post_cnt = CNT_W'(3);
    trig = 1; cyc(); trig = 0;
    strobe();
    pulse_stop();
    chk("R2 stop while armed", 64'(mode), 0);
    rd(DEPTH - 1, 1);
    rd(0, 2);
    repeat (4) cyc();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule